// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block builds the nominal bit time of a CAN node from a time-quantum clock enable. Each bit is split into a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. The length of each configurable segment comes from a biased register code: the length is the code plus one. The block watches the receive line for recessive-to-dominant transitions. It either restarts the bit on such a transition (hard synchronization) or corrects the bit length by a bounded amount (resynchronization), so that it tracks a transmitter whose oscillator drifts.

It produces two one-clock strobes. The sample strobe carries the sampled bit value. The transmit-point strobe marks the end of the sync quantum of each bit. Sampling takes one sample at the end of phase segment 1, or a majority of three samples on the last three quanta up to that point. A configuration check flags a phase segment 2 code that is zero or larger than the phase segment 1 code. The block is meant to sit behind a baud-rate prescaler and in front of a bit-stream engine.

Top module: `can_bit_timer`

## Requirements
- R1: With no receive edges, a bit lasts 1 + (PRS+1) + (PH1+1) + (PH2+1) quanta, and `tx_stb` pulses once per bit, for the quantum that closes the sync segment.
- R2: Without resynchronization, the sample quantum comes (PRS+1)+(PH1+1) quanta after the sync quantum, and the next sync quantum comes (PH2+1)+1 quanta after the sample quantum.
- R3: Timing advances only on clock cycles with `tq_en` high. No strobe is produced in the cycle after a cycle with `tq_en` low.
- R4: A falling edge (rx 1 then 0 on consecutive quanta) detected k quanta after the sync quantum, within the propagation segment or phase segment 1, delays the sample point and the bit end by min(k, SJW+1) quanta.
- R5: A falling edge in phase segment 2 on the quantum r quanta before the nominal bit end shortens the bit by min(r, SJW+1). When r ≤ SJW+1, the edge quantum becomes the new sync quantum and `tx_stb` pulses for it.
- R6: With `hsync_en` high, a falling edge makes its own quantum the sync quantum of a new bit, with no jump-width limit. `tx_stb` pulses for it, and the sample follows (PRS+1)+(PH1+1) quanta later.
- R7: At most one resynchronization takes effect per bit. Later falling edges in the same bit do not change its timing.
- R8: A falling edge in phase segment 2 of a bit whose sample was dominant (0) does not change the bit timing.
- R9: With `cfg_triple` = 0, `samp_bit` is the rx value on the sample quantum.
- R10: With `cfg_triple` = 1, `samp_bit` is the majority of the rx values on the sample quantum and the two quanta before it.
- R11: `cfg_err` is 1 exactly when the PH2 code is 0 or greater than the PH1 code, one clock after the codes are applied.
- R12: All outputs are registered and change one clock after the quantum that causes them. In reset, `samp_stb`, `tx_stb` and `cfg_err` are 0, `samp_bit` is 1 and the unit sits in the sync segment, so the first quantum after reset gives `tx_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tq_en | input | 1 | Time-quantum enable, one quantum per high cycle |
| cfg_sjw | input | 2 | Jump width code, width = code + 1 |
| cfg_prs | input | 3 | Propagation segment code, length = code + 1 |
| cfg_ph1 | input | 3 | Phase segment 1 code, length = code + 1 |
| cfg_ph2 | input | 3 | Phase segment 2 code, length = code + 1 |
| cfg_triple | input | 1 | 1 selects three-sample majority, 0 a single sample |
| hsync_en | input | 1 | Bus idle: falling edges hard-synchronize |
| rx | input | 1 | Receive line, 1 recessive, 0 dominant |
| samp_stb | output | 1 | One-clock pulse after the sample quantum |
| samp_bit | output | 1 | Sampled bit value, updated with `samp_stb` |
| tx_stb | output | 1 | One-clock pulse after each sync quantum |
| cfg_err | output | 1 | Illegal phase segment 2 code |

## Verification
The receive line is read on the quantum edge, so a value driven between edges belongs to the next quantum. Each strobe appears on the falling clock edge that follows its quantum. The bench aligns to an observed `tx_stb`, counts falling edges up to the quantum it wants to disturb, and predicts the exact number of falling edges to the next `samp_stb` or `tx_stb` from the segment codes and the jump width. Cycle counts scale by the enable spacing when quanta are spread out. `cfg_err` is checked one falling edge after each code change.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/can_bt_rxhist.sv
module can_bt_rxhist #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rx,
  output logic [DEPTH-1:0] hist,
  output logic             fall
);
  generate
    if (DEPTH > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)       hist <= '1;
        else if (tick) hist <= {hist[DEPTH-2:0], rx};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)       hist <= '1;
        else if (tick) hist <= rx;
      end
    end
  endgenerate

  // recessive on the previous quantum, dominant on this one
  assign fall = tick & hist[0] & ~rx;
endmodule

// File: rtl/can_bt_vote.sv
module can_bt_vote #(
  parameter int N = 3
) (
  input  logic [N-1:0] taps,
  input  logic         triple,
  output logic         bit_o
);
  localparam int HALF = N / 2;
  localparam int CW   = $clog2(N + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(taps[i]);
  end

  assign bit_o = triple ? (int'(ones) > HALF) : taps[0];
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             fall,
  input  logic             hsync,
  input  logic [CNT_W-1:0] sjw_len,
  input  logic [CNT_W-1:0] prs_len,
  input  logic [CNT_W-1:0] ph1_len,
  input  logic [CNT_W-1:0] ph2_len,
  input  logic             vote,
  output logic             samp_stb,
  output logic             samp_bit,
  output logic             tx_stb
);
  seg_e             seg, n_seg;
  logic [CNT_W-1:0] rem, n_rem;
  logic [CNT_W-1:0] pos, n_pos;
  logic [CNT_W-1:0] ext, n_ext;
  logic             done, n_done;
  logic             sbit, n_sbit;
  logic             do_samp, do_tx;
  logic [CNT_W-1:0] err_pos, lim_pos, eff;
  logic             resync;

  always_comb begin
    err_pos = pos + 1'b1;
    lim_pos = (err_pos < sjw_len) ? err_pos : sjw_len;
    resync  = fall && !done && !(seg == SEG_PH2 && !sbit);
    eff     = rem;

    n_seg   = seg;
    n_rem   = rem;
    n_pos   = pos;
    n_ext   = ext;
    n_done  = done;
    n_sbit  = sbit;
    do_samp = 1'b0;
    do_tx   = 1'b0;

    if (tick) begin
      if (fall && hsync) begin
        n_seg  = SEG_PROP;
        n_rem  = prs_len;
        n_pos  = '0;
        n_ext  = '0;
        n_done = 1'b0;
        do_tx  = 1'b1;
      end else begin
        unique case (seg)
          SEG_SYNC: begin
            n_seg  = SEG_PROP;
            n_rem  = prs_len;
            n_pos  = '0;
            n_ext  = '0;
            n_done = 1'b0;
            do_tx  = 1'b1;
          end
          SEG_PROP: begin
            n_pos = pos + 1'b1;
            if (resync) begin
              n_ext  = lim_pos;
              n_done = 1'b1;
            end
            if (rem == 1) begin
              n_seg = SEG_PH1;
              n_rem = ph1_len + (resync ? lim_pos : ext);
            end else begin
              n_rem = rem - 1'b1;
            end
          end
          SEG_PH1: begin
            n_pos = pos + 1'b1;
            if (resync) begin
              eff    = rem + lim_pos;
              n_done = 1'b1;
            end
            if (eff == 1) begin
              do_samp = 1'b1;
              n_sbit  = vote;
              n_seg   = SEG_PH2;
              n_rem   = ph2_len;
            end else begin
              n_rem = eff - 1'b1;
            end
          end
          default: begin
            if (resync) begin
              if (rem <= sjw_len) begin
                n_seg  = SEG_PROP;
                n_rem  = prs_len;
                n_pos  = '0;
                n_ext  = '0;
                n_done = 1'b0;
                do_tx  = 1'b1;
              end else if (rem == sjw_len + 1'b1) begin
                n_seg  = SEG_SYNC;
                n_rem  = CNT_W'(1);
                n_done = 1'b1;
              end else begin
                n_rem  = rem - 1'b1 - sjw_len;
                n_done = 1'b1;
              end
            end else if (rem == 1) begin
              n_seg = SEG_SYNC;
              n_rem = CNT_W'(1);
            end else begin
              n_rem = rem - 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg      <= SEG_SYNC;
      rem      <= CNT_W'(1);
      pos      <= '0;
      ext      <= '0;
      done     <= 1'b0;
      sbit     <= 1'b1;
      samp_stb <= 1'b0;
      samp_bit <= 1'b1;
      tx_stb   <= 1'b0;
    end else begin
      seg      <= n_seg;
      rem      <= n_rem;
      pos      <= n_pos;
      ext      <= n_ext;
      done     <= n_done;
      sbit     <= n_sbit;
      samp_stb <= do_samp;
      tx_stb   <= do_tx;
      if (do_samp) samp_bit <= vote;
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int SJW_W  = 2,
  parameter int SEG_W  = 3,
  parameter int VOTE_N = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tq_en,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic [SEG_W-1:0] cfg_prs,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic             cfg_triple,
  input  logic             hsync_en,
  input  logic             rx,
  output logic             samp_stb,
  output logic             samp_bit,
  output logic             tx_stb,
  output logic             cfg_err
);
  localparam int CNT_W = SEG_W + 2;
  localparam int HIST  = VOTE_N - 1;

  logic [CNT_W-1:0] sjw_len, prs_len, ph1_len, ph2_len;
  logic [HIST-1:0]  hist;
  logic             fall, vote;

  assign sjw_len = CNT_W'(cfg_sjw) + 1'b1;
  assign prs_len = CNT_W'(cfg_prs) + 1'b1;
  assign ph1_len = CNT_W'(cfg_ph1) + 1'b1;
  assign ph2_len = CNT_W'(cfg_ph2) + 1'b1;

  can_bt_rxhist #(.DEPTH(HIST)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .tick (tq_en),
    .rx   (rx),
    .hist (hist),
    .fall (fall)
  );

  can_bt_vote #(.N(VOTE_N)) u_vote (
    .taps   ({hist, rx}),
    .triple (cfg_triple),
    .bit_o  (vote)
  );

  can_bt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tq_en),
    .fall     (fall),
    .hsync    (hsync_en),
    .sjw_len  (sjw_len),
    .prs_len  (prs_len),
    .ph1_len  (ph1_len),
    .ph2_len  (ph2_len),
    .vote     (vote),
    .samp_stb (samp_stb),
    .samp_bit (samp_bit),
    .tx_stb   (tx_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= (cfg_ph2 == '0) || (cfg_ph2 > cfg_ph1);
  end
endmodule

// File: rtl/can_bt_chk.sv
module can_bt_chk #(
  parameter int SJW_W = 2,
  parameter int SEG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tq_en,
  input logic [SEG_W-1:0] cfg_ph1,
  input logic [SEG_W-1:0] cfg_ph2,
  input logic             cfg_triple,
  input logic             rx,
  input logic             samp_stb,
  input logic             samp_bit,
  input logic             tx_stb,
  input logic             cfg_err
);
  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(samp_stb && tx_stb));

  a_r3_no_strobe_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tq_en |=> (!samp_stb && !tx_stb));

  a_r12_samp_follows_tick: assert property (@(posedge clk) disable iff (rst)
    samp_stb |-> $past(tq_en));

  a_r9_single_sample_value: assert property (@(posedge clk) disable iff (rst)
    (samp_stb && !$past(cfg_triple)) |-> (samp_bit == $past(rx)));

  a_r11_zero_code_flagged: assert property (@(posedge clk) disable iff (rst)
    (cfg_ph2 == '0) |=> cfg_err);

  a_r11_legal_code_clean: assert property (@(posedge clk) disable iff (rst)
    (cfg_ph2 != '0 && cfg_ph2 <= cfg_ph1) |=> !cfg_err);
endmodule

bind can_bit_timer can_bt_chk #(.SJW_W(SJW_W), .SEG_W(SEG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tq_en      (tq_en),
  .cfg_ph1    (cfg_ph1),
  .cfg_ph2    (cfg_ph2),
  .cfg_triple (cfg_triple),
  .rx         (rx),
  .samp_stb   (samp_stb),
  .samp_bit   (samp_bit),
  .tx_stb     (tx_stb),
  .cfg_err    (cfg_err)
);

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tq_en = 1'b1;
  logic [1:0] cfg_sjw = 2'd0;
  logic [2:0] cfg_prs = 3'd2, cfg_ph1 = 3'd3, cfg_ph2 = 3'd3;
  logic       cfg_triple = 1'b0;
  logic       hsync_en = 1'b0;
  logic       rx = 1'b1;
  logic       samp_stb, samp_bit, tx_stb, cfg_err;

  int tests = 0, fails = 0;
  int div = 1, tq_ph = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  can_bit_timer u_dut (
    .clk(clk), .rst(rst), .tq_en(tq_en),
    .cfg_sjw(cfg_sjw), .cfg_prs(cfg_prs), .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2),
    .cfg_triple(cfg_triple), .hsync_en(hsync_en), .rx(rx),
    .samp_stb(samp_stb), .samp_bit(samp_bit), .tx_stb(tx_stb), .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    if (div <= 1) begin
      tq_en <= 1'b1;
      tq_ph <= 0;
    end else begin
      tq_en <= (tq_ph == 0);
      tq_ph <= (tq_ph + 1) % div;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tx();
    int n = 0;
    do begin @(negedge clk); n++; end while (!tx_stb && n < 400);
  endtask

  task automatic to_samp(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!samp_stb && n < 400);
  endtask

  task automatic to_tx(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tx_stb && n < 400);
  endtask

  // counts from an observed tx strobe; rx goes low so the edge lands on quantum k
  task automatic pos_edge_run(input int k, output int n);
    n = 0;
    if (k == 1) rx = 1'b0;
    do begin
      @(negedge clk); n++;
      if (n == k - 1) rx = 1'b0;
    end while (!samp_stb && n < 400);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, m, exp_n, sj, bl;

    // R12 reset state
    repeat (3) @(negedge clk);
    chk(samp_stb == 0 && tx_stb == 0, "R12 reset strobes", {samp_stb, tx_stb}, 0);
    chk(samp_bit == 1, "R12 reset samp_bit", samp_bit, 1);
    chk(cfg_err == 0, "R12 reset cfg_err", cfg_err, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_stb == 1, "R12 first quantum gives tx_stb", tx_stb, 1);

    // R1 / R2 exhaustive segment sweep
    for (int p = 0; p < 8; p++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          cfg_prs = 3'(p); cfg_ph1 = 3'(a); cfg_ph2 = 3'(b);
          wait_tx(); wait_tx();
          to_samp(n);
          chk(n == p + a + 2, "R2 sample offset", n, p + a + 2);
          to_tx(m);
          chk(m == b + 2, "R1 bit end after sample", m, b + 2);
        end

    // R3 spread quanta
    cfg_prs = 3'd2; cfg_ph1 = 3'd3; cfg_ph2 = 3'd3;
    div = 3;
    wait_tx(); wait_tx();
    to_samp(n);
    chk(n == 21, "R3 gated sample offset", n, 21);
    to_tx(m);
    chk(m == 15, "R3 gated bit end", m, 15);
    div = 1;
    repeat (4) @(negedge clk);

    // R4 positive phase error, R9 single sample value
    for (int s = 0; s < 4; s++)
      for (int k = 1; k <= 7; k++) begin
        cfg_sjw = 2'(s); sj = s + 1;
        rx = 1'b1; wait_tx(); wait_tx();
        pos_edge_run(k, n);
        exp_n = 7 + ((k < sj) ? k : sj);
        chk(n == exp_n, "R4 lengthened sample", n, exp_n);
        chk(samp_bit == 0, "R9 dominant sampled", samp_bit, 0);
        rx = 1'b1;
      end

    // R5 negative phase error (bit length 12)
    bl = 12;
    for (int s = 0; s < 4; s++)
      for (int r = 1; r <= 4; r++) begin
        cfg_sjw = 2'(s); sj = s + 1;
        rx = 1'b1; wait_tx(); wait_tx();
        n = 0;
        do begin
          @(negedge clk); n++;
          if (n == bl - r - 1) rx = 1'b0;
        end while (!tx_stb && n < 400);
        exp_n = bl - ((r < sj) ? r : sj);
        chk(n == exp_n, "R5 shortened bit", n, exp_n);
        rx = 1'b1;
      end

    // R7 second edge in one bit ignored
    cfg_sjw = 2'd3;
    rx = 1'b1; wait_tx(); wait_tx();
    rx = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) rx = 1'b1;
      if (n == 2) rx = 1'b0;
    end while (!samp_stb && n < 400);
    chk(n == 8, "R7 one resync per bit", n, 8);
    rx = 1'b1;

    // R8 no resync after a dominant sample
    rx = 1'b1; wait_tx(); wait_tx();
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 11) rx = 1'b0;
    end while (!tx_stb && n < 400);
    chk(n == 12, "R8 sync-quantum edge keeps period", n, 12);
    to_samp(n);
    chk(n == 7 && samp_bit == 0, "R8 dominant sample", n, 7);
    rx = 1'b1;
    @(negedge clk);
    rx = 1'b0;
    to_tx(m);
    chk(m == 4, "R8 phase-2 edge ignored", m + 1, 5);
    rx = 1'b1;

    // R6 hard synchronization
    hsync_en = 1'b1;
    for (int d = 1; d <= 11; d += 2) begin
      rx = 1'b1; wait_tx(); wait_tx();
      repeat (d) @(negedge clk);
      rx = 1'b0;
      to_tx(n);
      chk(n == 1, "R6 hard sync tx", n, 1);
      to_samp(m);
      chk(m == 7 && samp_bit == 0, "R6 hard sync sample", m, 7);
      rx = 1'b1;
    end
    hsync_en = 1'b0;

    // R9 / R10 sampling mode sweep (prs len 4, ph1 len 4, sjw 1)
    cfg_prs = 3'd3; cfg_ph1 = 3'd3; cfg_ph2 = 3'd3; cfg_sjw = 2'd0;
    for (int md = 0; md < 2; md++)
      for (int pat = 0; pat < 8; pat++) begin
        logic [2:0] pv;
        int ones;
        pv = 3'(pat);
        cfg_triple = md[0];
        rx = 1'b1; wait_tx(); wait_tx();
        rx = 1'b0;
        n = 0;
        do begin
          @(negedge clk); n++;
          if (n == 1) rx = 1'b1;
          if (n == 6) rx = pv[2];
          if (n == 7) rx = pv[1];
          if (n == 8) rx = pv[0];
        end while (!samp_stb && n < 400);
        ones = int'(pv[0]) + int'(pv[1]) + int'(pv[2]);
        exp_n = md ? ((ones >= 2) ? 1 : 0) : int'(pv[0]);
        chk(n == 9, "R10 sample point after resync", n, 9);
        if (md == 1) chk(samp_bit == exp_n[0], "R10 majority", samp_bit, exp_n);
        else         chk(samp_bit == exp_n[0], "R9 single sample", samp_bit, exp_n);
        rx = 1'b1;
      end
    cfg_triple = 1'b0;

    // R11 configuration check
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        cfg_ph1 = 3'(a); cfg_ph2 = 3'(b);
        @(negedge clk);
        exp_n = (b == 0 || b > a) ? 1 : 0;
        chk(cfg_err == exp_n[0], "R11 cfg_err", cfg_err, exp_n);
      end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule